// File: doc/BRIEF.md
# Monochrome Colour-Expansion Data Port

This block is the processor-fed monochrome expansion path of a 2D blit engine. Software describes a destination rectangle: base address, destination pitch, width and height in pixels, plus a foreground and a background 8-bit colour. It then launches the operation and streams the glyph bitmap in as 32-bit words. The block splits each word into bytes, turns every source bit into one 8-bit pixel (foreground for a set bit, background for a clear bit) and emits the pixels as single-pixel memory writes in raster order.

Each destination row consumes a whole number of source bytes, so a row always begins on a fresh byte. Bits of a row's last byte past the rectangle width are thrown away, as are unused bytes of the final data word. The engine stays busy until the number of words taken equals the needed word count rounded up to an even number, so the total is a multiple of 64 bits. When the needed count is odd, the source must push one more padding word, which is absorbed without any write.

Both data interfaces are valid/ready streams. An input word transfers on a clock edge where `src_valid_i` and `src_ready_o` are both high. The source must hold the word stable while ready is low. `src_ready_o` never depends on `src_valid_i`. A pixel write transfers on an edge where `pix_valid_o` and `pix_ready_i` are both high. While it is stalled, the block holds the address and data stable. The launch and busy pins are plain level/pulse controls.

Top module: `mono_expand_port`

## Requirements
- R1: After reset `busy_o`, `src_ready_o` and `pix_valid_o` are all 0.
- R2: A `start_i` pulse while idle captures the rectangle parameters and raises `busy_o` on the next clock edge. A `start_i` pulse while busy is ignored and leaves the running operation unchanged.
- R3: Each input word carries four source bytes. Bits 7:0 are consumed first, then 15:8, then 23:16, and bits 31:24 last.
- R4: Within a source byte, bit 7 gives the leftmost pixel of its group of eight. A set bit writes `fg_i` and a clear bit writes `bg_i`.
- R5: Each row takes ceil(width/8) source bytes and starts on a new byte. Bits of a row's last byte that lie beyond the width produce no write.
- R6: The pixel at column c of row r is written to address base + r*pitch + c. Writes are issued left to right within a row and rows top to bottom, one pixel per transfer.
- R7: Bytes of the final data word beyond the bytes the rectangle needs produce no write, whatever their value.
- R8: The block accepts exactly N words, where N is ceil(height*ceil(width/8)/4) rounded up to an even number. The padding word beyond the needed data produces no write. `busy_o` falls once all N words are taken and all pixels are written. While idle, `src_ready_o` and `pix_valid_o` stay 0.
- R9: While `pix_valid_o` is high and `pix_ready_i` is low, `pix_valid_o`, `pix_addr_o` and `pix_data_o` hold their values on the next cycle.
- R10: A launch with zero width or zero height takes no data words and issues no writes. `busy_o` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse, taken only while idle |
| dst_base_i | input | ADDR_W | Address of the top-left destination pixel |
| dst_pitch_i | input | PITCH_W | Byte distance between destination rows |
| rect_w_i | input | DIM_W | Rectangle width in pixels |
| rect_h_i | input | DIM_W | Rectangle height in rows |
| fg_i | input | 8 | Colour for set source bits |
| bg_i | input | 8 | Colour for clear source bits |
| busy_o | output | 1 | Operation in progress |
| src_valid_i | input | 1 | Source word valid |
| src_ready_o | output | 1 | Source word accepted this edge when valid |
| src_data_i | input | WORD_W | Source word, first byte in bits 7:0 |
| pix_valid_o | output | 1 | Pixel write valid |
| pix_ready_i | input | 1 | Pixel write accepted this edge when valid |
| pix_addr_o | output | ADDR_W | Pixel write address |
| pix_data_o | output | 8 | Pixel colour |

## Verification
The hardest cases to reach are the last pixel of the rectangle coinciding with the arrival of a trailing or padding byte, and a launch pulse landing mid-operation. The bench pushes words with irregular gaps while the pixel sink stalls on a pseudo-random pattern, so byte hand-offs and row ends meet under back-pressure. It uses rectangle shapes that give odd and even word counts, and fills the unused bytes of the last data word with a non-zero value. It fires a second launch with different parameters during a run. The scoreboard then shows that no stray write appears and that the word count and the fall of busy match the rounded-up total.

// File: rtl/mxp_pkg.sv
package mxp_pkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned PIX_BITS  = 8;
  typedef logic [PIX_BITS-1:0]  pix_t;
  typedef logic [BYTE_BITS-1:0] src_byte_t;
endpackage

// File: rtl/mxp_ctrl.sv
module mxp_ctrl #(
  parameter int unsigned DIM_W  = 12,
  parameter int unsigned CNT_W  = 2 * DIM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIM_W-1:0] rect_w_i,
  input  logic [DIM_W-1:0] rect_h_i,
  input  logic             src_valid_i,
  input  logic             up_in_ready_i,
  input  logic             up_empty_i,
  input  logic             exp_idle_i,
  output logic             src_ready_o,
  output logic             up_valid_o,
  output logic             launch_o,
  output logic             busy_o
);
  logic             busy_q;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] taken_q;
  logic [CNT_W-1:0] row_bytes_c, all_bytes_c, words_c, total_c;
  logic             more_words;
  logic             finish;

  // word count: bytes per row rounded up, words rounded up, then to even
  always_comb begin
    row_bytes_c = (CNT_W'(rect_w_i) + CNT_W'(7)) >> 3;
    all_bytes_c = row_bytes_c * CNT_W'(rect_h_i);
    words_c     = (all_bytes_c + CNT_W'(3)) >> 2;
    total_c     = words_c + CNT_W'(words_c[0]);
  end

  assign launch_o    = start_i && !busy_q;
  assign more_words  = busy_q && (taken_q != total_q);
  assign up_valid_o  = src_valid_i && more_words;
  assign src_ready_o = more_words && up_in_ready_i;
  assign finish      = busy_q && (taken_q == total_q) && up_empty_i && exp_idle_i;
  assign busy_o      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      total_q <= '0;
      taken_q <= '0;
    end else if (launch_o) begin
      busy_q  <= 1'b1;
      total_q <= total_c;
      taken_q <= '0;
    end else begin
      if (src_valid_i && src_ready_o) taken_q <= taken_q + CNT_W'(1);
      if (finish) busy_q <= 1'b0;
    end
  end

  p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |=> busy_q);
  p_busy_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !finish) |=> (busy_q && $stable(total_q)));
  p_word_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q <= total_q);
  p_even_total_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !total_q[0]);
endmodule

// File: rtl/mxp_unpack.sv
module mxp_unpack
  import mxp_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output src_byte_t         out_byte_o,
  output logic              empty_o
);
  localparam int unsigned LANES = WORD_W / BYTE_BITS;
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [WORD_W-1:0] word_q;
  logic              full_q;
  logic [IDX_W-1:0]  idx_q;
  src_byte_t         lane [LANES];
  logic              last_lane;
  logic              out_fire, in_fire;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_q[g*BYTE_BITS +: BYTE_BITS];
  end

  assign last_lane   = (idx_q == IDX_W'(LANES - 1));
  assign out_valid_o = full_q;
  assign out_byte_o  = lane[idx_q];
  assign out_fire    = full_q && out_ready_i;
  assign in_ready_o  = !full_q || (out_fire && last_lane);
  assign in_fire     = in_valid_i && in_ready_o;
  assign empty_o     = !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      full_q <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
    end else begin
      if (out_fire) begin
        if (last_lane) begin
          full_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
      if (in_fire) begin
        full_q <= 1'b1;
        word_q <= in_data_i;
        idx_q  <= '0;
      end
    end
  end

  p_lane_step_r3: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
    (out_fire && !last_lane) |=> (full_q && idx_q == $past(idx_q) + IDX_W'(1)));
  p_first_lane_r3: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
    in_fire |=> (full_q && idx_q == '0));
endmodule

// File: rtl/mxp_expand.sv
module mxp_expand
  import mxp_pkg::*;
#(
  parameter int unsigned DIM_W   = 12,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned PITCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [DIM_W-1:0]   width_i,
  input  logic [DIM_W-1:0]   height_i,
  input  pix_t               fg_i,
  input  pix_t               bg_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  src_byte_t          in_byte_i,
  output logic               pix_valid_o,
  input  logic               pix_ready_i,
  output logic [ADDR_W-1:0]  pix_addr_o,
  output pix_t               pix_data_o,
  output logic               idle_o
);
  localparam int unsigned BIT_W = $clog2(BYTE_BITS);

  src_byte_t          byte_q;
  logic               hold_q;
  logic               done_q;
  logic [BIT_W-1:0]   bit_q;
  logic [DIM_W-1:0]   col_q;
  logic [DIM_W-1:0]   rows_left_q;
  logic [DIM_W-1:0]   width_q;
  logic [ADDR_W-1:0]  row_base_q;
  logic [PITCH_W-1:0] pitch_q;
  pix_t               fg_q, bg_q;

  logic pix_fire, row_end, byte_end, finishing, in_fire, src_bit;

  assign src_bit     = byte_q[BIT_W'(BYTE_BITS - 1) - bit_q];
  assign pix_valid_o = hold_q;
  assign pix_addr_o  = row_base_q + ADDR_W'(col_q);
  assign pix_data_o  = src_bit ? fg_q : bg_q;
  assign pix_fire    = hold_q && pix_ready_i;
  assign row_end     = (col_q == width_q - DIM_W'(1));
  assign byte_end    = row_end || (bit_q == BIT_W'(BYTE_BITS - 1));
  assign finishing   = pix_fire && row_end && (rows_left_q == DIM_W'(1));
  assign in_ready_o  = !hold_q || (pix_fire && byte_end);
  assign in_fire     = in_valid_i && in_ready_o;
  assign idle_o      = !hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= 1'b0;
      done_q      <= 1'b1;
      byte_q      <= '0;
      bit_q       <= '0;
      col_q       <= '0;
      rows_left_q <= '0;
      width_q     <= '0;
      row_base_q  <= '0;
      pitch_q     <= '0;
      fg_q        <= '0;
      bg_q        <= '0;
    end else if (launch_i) begin
      hold_q      <= 1'b0;
      done_q      <= (width_i == '0) || (height_i == '0);
      bit_q       <= '0;
      col_q       <= '0;
      rows_left_q <= height_i;
      width_q     <= width_i;
      row_base_q  <= base_i;
      pitch_q     <= pitch_i;
      fg_q        <= fg_i;
      bg_q        <= bg_i;
    end else begin
      if (pix_fire) begin
        if (row_end) begin
          col_q       <= '0;
          bit_q       <= '0;
          row_base_q  <= row_base_q + ADDR_W'(pitch_q);
          rows_left_q <= rows_left_q - DIM_W'(1);
          if (rows_left_q == DIM_W'(1)) done_q <= 1'b1;
        end else begin
          col_q <= col_q + DIM_W'(1);
          bit_q <= bit_q + BIT_W'(1);
        end
        if (byte_end) hold_q <= 1'b0;
      end
      // bytes arriving once the rectangle is complete are sunk
      if (in_fire && !done_q && !finishing) begin
        hold_q <= 1'b1;
        byte_q <= in_byte_i;
      end
    end
  end

  p_pix_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && !pix_ready_i && !launch_i) |=>
      (pix_valid_o && $stable(pix_addr_o) && $stable(pix_data_o)));
  p_col_in_rect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (col_q < width_q));
  p_no_write_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !pix_valid_o);
  p_row_start_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fire && row_end && !launch_i) |=> (bit_q == '0 && col_q == '0));
endmodule

// File: rtl/mono_expand_port.sv
module mono_expand_port
  import mxp_pkg::*;
#(
  parameter int unsigned DIM_W   = 12,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned PITCH_W = 16,
  parameter int unsigned WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  dst_base_i,
  input  logic [PITCH_W-1:0] dst_pitch_i,
  input  logic [DIM_W-1:0]   rect_w_i,
  input  logic [DIM_W-1:0]   rect_h_i,
  input  logic [7:0]         fg_i,
  input  logic [7:0]         bg_i,
  output logic               busy_o,
  input  logic               src_valid_i,
  output logic               src_ready_o,
  input  logic [WORD_W-1:0]  src_data_i,
  output logic               pix_valid_o,
  input  logic               pix_ready_i,
  output logic [ADDR_W-1:0]  pix_addr_o,
  output logic [7:0]         pix_data_o
);
  localparam int unsigned CNT_W = 2 * DIM_W;

  logic      up_valid, up_in_ready, up_empty;
  logic      byte_valid, byte_ready;
  src_byte_t byte_data;
  logic      exp_idle, launch;
  pix_t      pix_data;

  mxp_ctrl #(.DIM_W(DIM_W), .CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .rect_w_i      (rect_w_i),
    .rect_h_i      (rect_h_i),
    .src_valid_i   (src_valid_i),
    .up_in_ready_i (up_in_ready),
    .up_empty_i    (up_empty),
    .exp_idle_i    (exp_idle),
    .src_ready_o   (src_ready_o),
    .up_valid_o    (up_valid),
    .launch_o      (launch),
    .busy_o        (busy_o)
  );

  mxp_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (launch),
    .in_valid_i  (up_valid),
    .in_ready_o  (up_in_ready),
    .in_data_i   (src_data_i),
    .out_valid_o (byte_valid),
    .out_ready_i (byte_ready),
    .out_byte_o  (byte_data),
    .empty_o     (up_empty)
  );

  mxp_expand #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_expand (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (launch),
    .base_i      (dst_base_i),
    .pitch_i     (dst_pitch_i),
    .width_i     (rect_w_i),
    .height_i    (rect_h_i),
    .fg_i        (fg_i),
    .bg_i        (bg_i),
    .in_valid_i  (byte_valid),
    .in_ready_o  (byte_ready),
    .in_byte_i   (byte_data),
    .pix_valid_o (pix_valid_o),
    .pix_ready_i (pix_ready_i),
    .pix_addr_o  (pix_addr_o),
    .pix_data_o  (pix_data),
    .idle_o      (exp_idle)
  );

  assign pix_data_o = pix_data;

  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!pix_valid_o && !src_ready_o));
  p_reset_state_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!busy_o && !pix_valid_o && !src_ready_o));
endmodule

// File: tb/mono_expand_port_tb_top.sv
module mono_expand_port_tb_top;
  localparam int DIM_W = 12, ADDR_W = 24, PITCH_W = 16, WORD_W = 32;

  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic               start_i = 0;
  logic [ADDR_W-1:0]  dst_base_i = '0;
  logic [PITCH_W-1:0] dst_pitch_i = '0;
  logic [DIM_W-1:0]   rect_w_i = '0, rect_h_i = '0;
  logic [7:0]         fg_i = '0, bg_i = '0;
  logic               busy_o, src_ready_o, pix_valid_o;
  logic               src_valid_i = 0;
  logic [WORD_W-1:0]  src_data_i = '0;
  logic               pix_ready_i = 1;
  logic [ADDR_W-1:0]  pix_addr_o;
  logic [7:0]         pix_data_o;

  mono_expand_port #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dst_base_i(dst_base_i),
    .dst_pitch_i(dst_pitch_i), .rect_w_i(rect_w_i), .rect_h_i(rect_h_i),
    .fg_i(fg_i), .bg_i(bg_i), .busy_o(busy_o), .src_valid_i(src_valid_i),
    .src_ready_o(src_ready_o), .src_data_i(src_data_i), .pix_valid_o(pix_valid_o),
    .pix_ready_i(pix_ready_i), .pix_addr_o(pix_addr_o), .pix_data_o(pix_data_o));

  int checks = 0, errors = 0;
  logic [ADDR_W+7:0] expq[$];
  logic [7:0] lfsr = 8'h5B;
  bit stall_mode = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pick ready at negedge, compare the transfer that the next edge takes
  bit prev_stall = 0;
  logic [ADDR_W+7:0] prev_item;
  always begin
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    pix_ready_i = stall_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
    #2;
    if (rst_n) begin
      if (prev_stall && pix_valid_o)
        chk({pix_addr_o, pix_data_o} == prev_item, "R9 stalled write changed",
            {pix_addr_o, pix_data_o}, prev_item);
      prev_stall = pix_valid_o && !pix_ready_i;
      prev_item  = {pix_addr_o, pix_data_o};
      if (pix_valid_o && pix_ready_i) begin
        if (expq.size() == 0) begin
          chk(0, "R7 R8 unexpected pixel write", {pix_addr_o, pix_data_o}, 0);
        end else begin
          logic [ADDR_W+7:0] e;
          e = expq.pop_front();
          chk({pix_addr_o, pix_data_o} == e, "R3 R4 R5 R6 pixel addr/data",
              {pix_addr_o, pix_data_o}, e);
        end
      end
    end
  end

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    src_valid_i = 1;
    src_data_i  = w;
    #1;
    while (!src_ready_o) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    #1;
    while (busy_o && n < 3000) begin
      @(negedge clk);
      #1;
      n++;
    end
  endtask

  function automatic logic [7:0] glyph(input int seed, input int r, input int k);
    logic [7:0] v;
    v = 8'((seed * 37) + (r * 13) + (k * 91));
    return v ^ 8'((r + k) * 5 + seed);
  endfunction

  task automatic run_rect(input int base, input int pitch, input int w, input int h,
                          input logic [7:0] fg, input logic [7:0] bg, input int seed,
                          input bit inject, input string tag);
    int bpr, nbytes, nwords, total;
    logic [7:0] bytes[$];
    bpr    = (w + 7) / 8;
    nbytes = (w == 0 || h == 0) ? 0 : bpr * h;
    nwords = (nbytes + 3) / 4;
    total  = nwords + (nwords % 2);
    for (int r = 0; r < h; r++)
      for (int k = 0; k < bpr; k++) bytes.push_back(glyph(seed, r, k));
    if (w != 0)
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++) begin
          logic [7:0] b;
          b = bytes[r * bpr + c / 8];
          expq.push_back({ADDR_W'(base + r * pitch + c), (b[7 - (c % 8)] ? fg : bg)});
        end
    @(negedge clk);
    dst_base_i = ADDR_W'(base); dst_pitch_i = PITCH_W'(pitch);
    rect_w_i = DIM_W'(w); rect_h_i = DIM_W'(h); fg_i = fg; bg_i = bg;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    #1;
    chk(busy_o == 1, {"R2 busy after launch ", tag}, busy_o, 1);
    for (int i = 0; i < total; i++) begin
      logic [31:0] wd;
      for (int b = 0; b < 4; b++) begin
        int ix;
        ix = i * 4 + b;
        wd[b*8 +: 8] = (ix < nbytes) ? bytes[ix] : ((i < nwords) ? 8'hA5 : 8'h00);
      end
      if (i == total - 1) begin
        @(negedge clk);
        #1;
        chk(busy_o == 1, {"R8 busy before last word ", tag}, busy_o, 1);
      end
      push_word(wd);
      if (i % 3 == 1) begin
        @(negedge clk);
        src_valid_i = 0;
      end
      if (inject && i == 0) begin
        @(negedge clk);
        src_valid_i = 0;
        rect_w_i = 3; rect_h_i = 1; dst_base_i = '0; fg_i = 8'h11; start_i = 1;
        @(negedge clk);
        start_i = 0;
      end
    end
    @(negedge clk);
    src_valid_i = 0;
    wait_idle();
    chk(busy_o == 0, {"R8 busy falls ", tag}, busy_o, 0);
    chk(expq.size() == 0, {"R5 R7 all writes seen ", tag}, expq.size(), 0);
    // one more word offered while idle must not be taken
    src_valid_i = 1; src_data_i = 32'hFFFF_FFFF;
    begin
      bit taken = 0;
      for (int n = 0; n < 4; n++) begin
        @(negedge clk);
        #1;
        if (src_ready_o || pix_valid_o) taken = 1;
      end
      chk(!taken, {"R8 idle refuses words ", tag}, taken, 0);
    end
    src_valid_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy_o && !src_ready_o && !pix_valid_o, "R1 reset state",
        {busy_o, src_ready_o, pix_valid_o}, 0);
    rst_n = 1;
    // R3 R4 R5 R6: two bytes per row, even word count
    run_rect(100, 64, 13, 3, 8'hF0, 8'h0F, 1, 0, "w13h3");
    // R8: single needed word, pad word required
    run_rect(4000, 32, 8, 2, 8'h7E, 8'h81, 2, 0, "w8h2");
    // R7: unused bytes of last data word carry 0xA5
    run_rect(20, 16, 5, 5, 8'hC3, 8'h3C, 3, 0, "w5h5");
    stall_mode = 1;
    run_rect(512, 100, 20, 4, 8'hAA, 8'h55, 4, 0, "w20h4 stall");
    run_rect(7, 9, 1, 1, 8'h12, 8'h34, 5, 0, "w1h1 stall");
    // R2: second launch during a run is ignored
    run_rect(300, 40, 9, 7, 8'h99, 8'h66, 6, 1, "w9h7 inject");
    stall_mode = 0;
    // R10: zero width takes nothing and writes nothing
    run_rect(50, 8, 0, 4, 8'h01, 8'h02, 7, 0, "R10 zero width");
    run_rect(50, 8, 6, 0, 8'h01, 8'h02, 8, 0, "R10 zero height");
    run_rect(1000, 256, 33, 3, 8'hE7, 8'h18, 9, 0, "w33h3");
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule